// File: doc/BRIEF.md
# Region-Safe Next Program Counter Unit

This unit produces the next fetch address for a processor whose code space is 24 bits wide. The top byte of the address picks one of 256 regions and the lower 16 bits are the offset inside that region. On each accepted request, the unit receives four things: the address of the current instruction, its length in bytes, the kind of control transfer and an immediate field. One clock later it returns the address at which fetch continues.

There are four kinds of transfer. A sequential advance steps past the instruction. A short relative branch adds a signed byte to the address of the following instruction. A 16-bit absolute jump stays in the region of the following instruction. An extended jump loads a full 24-bit target. Every calculation uses the whole 24-bit address, so an instruction near a region edge behaves exactly like one in the middle of a region. Relative targets borrow from, or carry into, the region byte when they cross an edge. The extended target is never changed by the increment of the current address.

Top module: `branch_target_gen`

## Requirements
- R1: While reset is asserted and after its release, `nextPc` equals the parameter `RESET_VEC` (default 24'hFF0000) and `outValid` is 0 until the first request is accepted.
- R2: A request sampled with `inValid` high at a rising edge sets `outValid` to 1 after that edge. A cycle with `inValid` low sets `outValid` to 0 after the edge.
- R3: A cycle with `inValid` low leaves `nextPc` unchanged, whatever the other inputs are.
- R4: When `kind` is 2'b00 (sequential), `nextPc` becomes `pcIn + instLen` modulo 2^24, and a carry out of bit 15 goes into the region byte (FF:FFFE with length 3 gives 00:0001).
- R5: When `kind` is 2'b01 (short relative), `nextPc` becomes `pcIn + instLen + sext(imm[7:0])` modulo 2^24. Bits 23:8 of `imm` have no effect.
- R6: A short relative branch whose target lies in the region below reaches that region: an instruction at FF:0002 of length 2 with displacement 8'hEC lands at FE:FFF0.
- R7: Short relative branches resolve correctly in both directions across the FE:/FF: and 00:/01: boundaries, including the extreme displacements +127 and -128.
- R8: When `kind` is 2'b10 (absolute 16-bit), `nextPc` takes bits 23:16 from `pcIn + instLen` and bits 15:0 from `imm[15:0]`. Bits 23:16 of `imm` have no effect.
- R9: When `kind` is 2'b11 (extended), `nextPc` equals `imm` exactly, independent of `pcIn` and `instLen`. An instruction at FE:FFFD of length 4 that targets 00:1234 lands at 00:1234.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; the inputs below are sampled when it is high |
| pcIn | input | 24 | Address of the current instruction |
| instLen | input | 3 | Instruction length in bytes (1 to 5) |
| kind | input | 2 | Transfer kind: 00 sequential, 01 short relative, 10 absolute 16-bit, 11 extended |
| imm | input | 24 | Displacement (bits 7:0), 16-bit target (bits 15:0) or 24-bit target |
| nextPc | output | 24 | Registered next program counter |
| outValid | output | 1 | High for one cycle after each accepted request |

## Verification
The bench builds the unit with its default parameters: a 24-bit address, an 8-bit region byte, an 8-bit displacement and a 3-bit length. With these values, wrap-around modulo 2^24 and every region edge can be reached by directed addresses. The random requests pick offsets within a few bytes of 0000 or FFFF and regions at 00, 01, FE or FF about half of the time. This steers carries and borrows through the region byte far more often than uniform addresses would. Junk in the unused upper bits of `imm` and idle cycles with random inputs check the ignore and hold rules at the outputs.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    KIND_SEQ = 2'b00,
    KIND_REL = 2'b01,
    KIND_ABS = 2'b10,
    KIND_EXT = 2'b11
  } branchKind_e;

  typedef struct packed {
    logic load;
    logic useSeq;
    logic useRel;
    logic useAbs;
    logic useExt;
  } btStrobe_t;

endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
(
  input  logic        inValid,
  input  logic [1:0]  kind,
  output btStrobe_t   strb
);

  branchKind_e kindE;

  always_comb begin
    kindE = branchKind_e'(kind);
    strb = '0;
    strb.load = inValid;
    unique case (kindE)
      KIND_SEQ: strb.useSeq = 1'b1;
      KIND_REL: strb.useRel = 1'b1;
      KIND_ABS: strb.useAbs = 1'b1;
      KIND_EXT: strb.useExt = 1'b1;
      default:  strb.useSeq = 1'b1;
    endcase
  end

endmodule

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REGION_W = 8,
  parameter int DISP_W = 8,
  parameter int LEN_W = 3,
  parameter logic [ADDR_W-1:0] RESET_VEC = 24'hFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  btStrobe_t         strb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [ADDR_W-1:0] imm,
  output logic [ADDR_W-1:0] nextPc,
  output logic              outValid
);

  localparam int OFF_W = ADDR_W - REGION_W;
  localparam int LEN_PAD = ADDR_W - LEN_W;
  localparam int DISP_PAD = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] lenExt;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] relPc;
  logic [ADDR_W-1:0] absPc;
  logic [ADDR_W-1:0] pcSel;

  assign lenExt  = {{LEN_PAD{1'b0}}, instLen};
  assign dispExt = {{DISP_PAD{imm[DISP_W-1]}}, imm[DISP_W-1:0]};

  // Full-width adders: region byte takes part in every carry and borrow.
  assign seqPc = pcIn + lenExt;
  assign relPc = seqPc + dispExt;
  assign absPc = {seqPc[ADDR_W-1:OFF_W], imm[OFF_W-1:0]};

  always_comb begin
    pcSel = seqPc;
    if (strb.useRel) pcSel = relPc;
    if (strb.useAbs) pcSel = absPc;
    if (strb.useExt) pcSel = imm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc   <= RESET_VEC;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.load;
      if (strb.load) nextPc <= pcSel;
    end
  end

  // R2
  valid_follows_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid);

  // R2
  valid_drops_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !outValid);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(nextPc));

  // R4
  one_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> $onehot({strb.useSeq, strb.useRel, strb.useAbs, strb.useExt}));

  // R8
  abs_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.useAbs) |=> nextPc[OFF_W-1:0] == $past(imm[OFF_W-1:0]));

  // R9
  ext_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.useExt) |=> nextPc == $past(imm));

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import bt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REGION_W = 8,
  parameter int DISP_W = 8,
  parameter int LEN_W = 3,
  parameter logic [ADDR_W-1:0] RESET_VEC = 24'hFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] imm,
  output logic [ADDR_W-1:0] nextPc,
  output logic              outValid
);

  btStrobe_t strb;

  bt_ctrl u_ctrl (
    .inValid (inValid),
    .kind    (kind),
    .strb    (strb)
  );

  bt_datapath #(
    .ADDR_W    (ADDR_W),
    .REGION_W  (REGION_W),
    .DISP_W    (DISP_W),
    .LEN_W     (LEN_W),
    .RESET_VEC (RESET_VEC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pcIn     (pcIn),
    .instLen  (instLen),
    .imm      (imm),
    .nextPc   (nextPc),
    .outValid (outValid)
  );

endmodule

// File: tb/branch_target_gen_bench.sv
module branch_target_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] pcIn = '0;
  logic [2:0]  instLen = 3'd1;
  logic [1:0]  kind = 2'b00;
  logic [23:0] imm = '0;
  logic [23:0] nextPc;
  logic        outValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  branch_target_gen u_branch_target_gen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pcIn(pcIn),
    .instLen(instLen), .kind(kind), .imm(imm),
    .nextPc(nextPc), .outValid(outValid)
  );

  function automatic logic [23:0] expectPc(logic [23:0] pc, logic [2:0] len,
                                           logic [1:0] k, logic [23:0] im);
    logic [23:0] nxt;
    nxt = pc + {21'd0, len};
    case (k)
      2'b00:   return nxt;
      2'b01:   return nxt + {{16{im[7]}}, im[7:0]};
      2'b10:   return {nxt[23:16], im[15:0]};
      default: return im;
    endcase
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Returns the requirement tag for a given kind
  function automatic string kindTag(logic [1:0] k);
    case (k)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic request(logic [23:0] pc, logic [2:0] len, logic [1:0] k,
                         logic [23:0] im, string tag);
    logic [23:0] exp;
    logic [23:0] held;
    exp = expectPc(pc, len, k, im);
    inValid = 1'b1; pcIn = pc; instLen = len; kind = k; imm = im;
    @(negedge clk);
    check({tag, " nextPc"}, nextPc, exp);
    check("R2 outValid after request", {23'd0, outValid}, 24'd1);
    held = nextPc;
    inValid = 1'b0;
    pcIn = 24'($urandom); instLen = 3'($urandom_range(1, 5));
    kind = 2'($urandom); imm = 24'($urandom);
    @(negedge clk);
    check("R3 idle hold", nextPc, held);
    check("R2 outValid idle", {23'd0, outValid}, 24'd0);
  endtask

  function automatic logic [23:0] edgyPc();
    logic [7:0]  reg8;
    logic [15:0] off;
    if ($urandom_range(0, 1) == 0) begin
      case ($urandom_range(0, 3))
        0: reg8 = 8'h00;
        1: reg8 = 8'h01;
        2: reg8 = 8'hFE;
        default: reg8 = 8'hFF;
      endcase
      off = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 7))
                                        : 16'hFFFF - 16'($urandom_range(0, 7));
      return {reg8, off};
    end
    return 24'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset state held during reset
    check("R1 reset nextPc", nextPc, 24'hFF0000);
    check("R1 reset outValid", {23'd0, outValid}, 24'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset nextPc", nextPc, 24'hFF0000);
    check("R1 post-reset outValid", {23'd0, outValid}, 24'd0);

    request(24'hFFFFFE, 3'd3, 2'b00, 24'h0, "R4 wrap");
    request(24'h00FFFF, 3'd1, 2'b00, 24'h0, "R4 region carry");
    request(24'hFF0002, 3'd2, 2'b01, 24'h0000EC, "R6 back to FE");
    check("R6 literal", expectPc(24'hFF0002, 3'd2, 2'b01, 24'hEC), 24'hFEFFF0);
    request(24'hFEFFF0, 3'd2, 2'b01, 24'h000020, "R7 FE up to FF");
    request(24'h00FFF8, 3'd2, 2'b01, 24'h00007F, "R7 00 up to 01 +127");
    request(24'h010002, 3'd2, 2'b01, 24'h000080, "R7 01 down to 00 -128");
    request(24'hFF0000, 3'd3, 2'b01, 24'h0000F0, "R7 FF down to FE");
    request(24'h000000, 3'd2, 2'b01, 24'h000080, "R5 wrap below zero");
    request(24'h123456, 3'd3, 2'b01, 24'hABCD05, "R5 upper imm ignored");
    request(24'hFEFFFE, 3'd3, 2'b10, 24'h771234, "R8 next region kept");
    request(24'hFEFFFD, 3'd4, 2'b11, 24'h001234, "R9 top of region");
    request(24'hFFFFFF, 3'd5, 2'b11, 24'hFFFFFF, "R9 all ones");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] k;
      k = 2'($urandom);
      request(edgyPc(), 3'($urandom_range(1, 5)), k, 24'($urandom), kindTag(k));
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      summary();
      $finish;
    end
  end

endmodule